// File: doc/BRIEF.md
# Direct Peer Request Span Checker

This block decides whether a direct peer-to-peer memory request, one that bypasses the host and targets device memory behind a single address decoder, can be completed by that decoder. Each request carries a start address, a byte count and a flag saying the address has already been translated. The decoder side supplies its window base, its window size, the log2 of its interleave chunk size and an enable saying it serves direct peer requests.

A request is accepted only when every condition holds:
- the decoder serves direct requests;
- the address is translated;
- the byte count is non-zero;
- the last byte does not run past the top of the address space;
- the whole span from the first to the last byte sits inside the window;
- the first and last bytes fall in the same interleave chunk.

Any failure gives a completer-abort. The verdict is registered and appears one clock after the request is presented. The block computes the last byte as start plus count minus one. It finds a chunk crossing by comparing the first and last byte addresses after both are shifted right by the chunk log2.

Top module: `p2p_span_checker`

## Requirements
- R1: While reset (rst_n low) is applied and on the first cycle after it, rsp_valid, rsp_accept and rsp_abort are all low.
- R2: rsp_valid is high in exactly the cycle after a cycle with req_valid high, and low otherwise. When rsp_valid is high, exactly one of rsp_accept and rsp_abort is high. When rsp_valid is low, both are low.
- R3: A request presented while dec_p2p_en is 0 is answered with rsp_abort.
- R4: A request with req_translated equal to 0 is answered with rsp_abort.
- R5: A request with req_len equal to 0 is answered with rsp_abort.
- R6: Let last = req_addr + req_len - 1. A request with req_addr < dec_base, or with last >= dec_base + dec_size, is answered with rsp_abort. A dec_size of 0 therefore refuses every request.
- R7: A request whose req_addr >> dec_gran_log differs from last >> dec_gran_log (it crosses a 2^dec_gran_log byte chunk boundary) is answered with rsp_abort.
- R8: A request whose last exceeds 2^ADDR_W - 1 (the span wraps past the top of the address space) is answered with rsp_abort.
- R9: A request that meets none of the abort conditions of R3 to R8 is answered with rsp_accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_addr | input | ADDR_W | First byte address of the request |
| req_len | input | LEN_W | Byte count of the request (LEN_W < ADDR_W) |
| req_translated | input | 1 | Address has already been translated |
| dec_base | input | ADDR_W | First byte address of the decoder window |
| dec_size | input | ADDR_W+1 | Window size in bytes |
| dec_gran_log | input | GL_W | log2 of the interleave chunk size in bytes |
| dec_p2p_en | input | 1 | Decoder serves direct peer requests |
| rsp_valid | output | 1 | Verdict is present this cycle |
| rsp_accept | output | 1 | Request can be completed |
| rsp_abort | output | 1 | Request gets a completer-abort |

## Verification
A window-edge failure and a chunk-boundary crossing can both be true for the same request. They then have to merge into a single abort, never into a cleared verdict or into both outputs at once. The bench sweeps every start address and every byte count against windows whose edges are not chunk-aligned. This makes many spans overrun the window and straddle a chunk edge in the same cycle. Spans at the top of a window that reaches the end of the address space also trip the wrap test together with these two. Each verdict is judged against a reference that evaluates the conditions independently in integer arithmetic and files the check under the first failing requirement.

// File: rtl/p2p_chk_pkg.sv
package p2p_chk_pkg;

  // One pass bit per acceptance condition; the request is accepted only if all are set.
  typedef struct packed {
    logic cap_ok;     // decoder serves direct requests
    logic xlat_ok;    // address already translated
    logic len_ok;     // non-zero byte count
    logic nowrap_ok;  // last byte inside the address space
    logic win_ok;     // whole span inside the window
    logic chunk_ok;   // span inside one interleave chunk
  } chk_flags_t;

  function automatic logic all_pass(input chk_flags_t f);
    return f.cap_ok & f.xlat_ok & f.len_ok & f.nowrap_ok & f.win_ok & f.chunk_ok;
  endfunction

endpackage

// File: rtl/p2p_span_calc.sv
module p2p_span_calc #(
  parameter int ADDR_W = 52,
  parameter int LEN_W  = 13
) (
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  byte_cnt,
  output logic [ADDR_W:0]   last_ext,
  output logic              len_zero,
  output logic              span_wraps
);
  localparam int EXT_W = ADDR_W + 1;

  // Last byte address, one bit wider than the address so a wrap shows as a carry.
  function automatic logic [EXT_W-1:0] last_byte(input logic [ADDR_W-1:0] a,
                                                 input logic [LEN_W-1:0] n);
    logic [EXT_W-1:0] sum;
    sum = {1'b0, a} + EXT_W'(n);
    return sum - EXT_W'(1);
  endfunction

  always_comb begin
    last_ext   = last_byte(start_addr, byte_cnt);
    len_zero   = (byte_cnt == '0);
    span_wraps = !len_zero && last_ext[ADDR_W];
  end
endmodule

// File: rtl/p2p_window_cmp.sv
module p2p_window_cmp #(
  parameter int ADDR_W = 52
) (
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W:0]   last_ext,
  input  logic [ADDR_W-1:0] win_base,
  input  logic [ADDR_W:0]   win_size,
  output logic              win_hit
);
  localparam int EXT_W = ADDR_W + 1;

  // Exclusive upper bound of the window; the extra bit keeps a full-size window exact.
  function automatic logic [EXT_W-1:0] win_limit(input logic [ADDR_W-1:0] b,
                                                 input logic [EXT_W-1:0] s);
    return {1'b0, b} + s;
  endfunction

  logic [EXT_W-1:0] limit_ext;
  logic             lo_ok;
  logic             hi_ok;

  always_comb begin
    limit_ext = win_limit(win_base, win_size);
    lo_ok     = (start_addr >= win_base);
    hi_ok     = (last_ext < limit_ext);
    win_hit   = lo_ok && hi_ok;
  end
endmodule

// File: rtl/p2p_chunk_cmp.sv
module p2p_chunk_cmp #(
  parameter int ADDR_W    = 52,
  parameter int GL_W      = 6,
  parameter bit MASK_FORM = 1'b1
) (
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic [GL_W-1:0]   gran_log,
  output logic              same_chunk
);
  // Chunk index of an address for a chunk of 2^g bytes.
  function automatic logic [ADDR_W-1:0] chunk_idx(input logic [ADDR_W-1:0] a,
                                                  input logic [GL_W-1:0] g);
    return a >> g;
  endfunction

  // Mask that clears the byte-within-chunk bits.
  function automatic logic [ADDR_W-1:0] chunk_mask(input logic [GL_W-1:0] g);
    return {ADDR_W{1'b1}} << g;
  endfunction

  generate
    if (MASK_FORM) begin : g_mask
      // One XOR and one reduce: shallower than two barrel shifters.
      always_comb same_chunk = (((start_addr ^ last_addr) & chunk_mask(gran_log)) == '0);
    end else begin : g_shift
      always_comb same_chunk = (chunk_idx(start_addr, gran_log) == chunk_idx(last_addr, gran_log));
    end
  endgenerate
endmodule

// File: rtl/p2p_span_checker.sv
module p2p_span_checker
  import p2p_chk_pkg::*;
#(
  parameter int ADDR_W    = 52,
  parameter int LEN_W     = 13,
  parameter int GL_W      = $clog2(ADDR_W),
  parameter bit MASK_FORM = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_translated,
  input  logic [ADDR_W-1:0] dec_base,
  input  logic [ADDR_W:0]   dec_size,
  input  logic [GL_W-1:0]   dec_gran_log,
  input  logic              dec_p2p_en,
  output logic              rsp_valid,
  output logic              rsp_accept,
  output logic              rsp_abort
);
  // Named internal events, brought out for the assertions.
  logic [ADDR_W:0] last_ext;
  logic            len_zero;
  logic            span_wraps;
  logic            win_hit;
  logic            same_chunk;
  chk_flags_t      flags;
  logic            grant;

  p2p_span_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_span (
    .start_addr (req_addr),
    .byte_cnt   (req_len),
    .last_ext   (last_ext),
    .len_zero   (len_zero),
    .span_wraps (span_wraps)
  );

  p2p_window_cmp #(.ADDR_W(ADDR_W)) u_window (
    .start_addr (req_addr),
    .last_ext   (last_ext),
    .win_base   (dec_base),
    .win_size   (dec_size),
    .win_hit    (win_hit)
  );

  p2p_chunk_cmp #(.ADDR_W(ADDR_W), .GL_W(GL_W), .MASK_FORM(MASK_FORM)) u_chunk (
    .start_addr (req_addr),
    .last_addr  (last_ext[ADDR_W-1:0]),
    .gran_log   (dec_gran_log),
    .same_chunk (same_chunk)
  );

  always_comb begin
    flags.cap_ok    = dec_p2p_en;
    flags.xlat_ok   = req_translated;
    flags.len_ok    = !len_zero;
    flags.nowrap_ok = !span_wraps;
    flags.win_ok    = win_hit;
    flags.chunk_ok  = same_chunk;
    grant           = all_pass(flags);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_accept <= 1'b0;
      rsp_abort  <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_accept <= req_valid && grant;
      rsp_abort  <= req_valid && !grant;
    end
  end

  // R2: a verdict appears exactly one cycle after each request.
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !rsp_accept && !rsp_abort);
  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_accept, rsp_abort}) == 1);
  // R3
  a_r3_cap_off: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !dec_p2p_en |=> rsp_abort);
  // R4
  a_r4_untranslated: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_translated |=> rsp_abort);
  // R5
  a_r5_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_len == '0) |=> rsp_abort);
  // R6
  a_r6_outside_window: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !win_hit |=> rsp_abort);
  // R7
  a_r7_chunk_cross: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !same_chunk |=> rsp_abort);
  // R8
  a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && span_wraps |=> rsp_abort);
  // R9
  a_r9_accept_clean: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && dec_p2p_en && req_translated && !len_zero && !span_wraps
      && win_hit && same_chunk |=> rsp_accept);
endmodule

// File: tb/test_p2p_span_checker.sv
module test_p2p_span_checker;
  localparam int AW = 8;
  localparam int LW = 4;
  localparam int GW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic          req_translated = 1'b0;
  logic [AW-1:0] dec_base = '0;
  logic [AW:0]   dec_size = '0;
  logic [GW-1:0] dec_gran_log = '0;
  logic          dec_p2p_en = 1'b0;
  logic          rsp_valid, rsp_accept, rsp_abort;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  p2p_span_checker #(.ADDR_W(AW), .LEN_W(LW), .GL_W(GW)) i_p2p_span_checker (
    .clk, .rst_n, .req_valid, .req_addr, .req_len, .req_translated,
    .dec_base, .dec_size, .dec_gran_log, .dec_p2p_en,
    .rsp_valid, .rsp_accept, .rsp_abort
  );

  task automatic check3(input string req, input logic v, input logic a, input logic b,
                        input logic ev, input logic ea, input logic eb);
    checks++;
    if (v !== ev || a !== ea || b !== eb) begin
      failures++;
      $display("FAIL %s: valid/accept/abort=%b%b%b expected %b%b%b", req, v, a, b, ev, ea, eb);
    end
  endtask

  // Reference verdict in plain integers; returns the tag of the first failing rule, or R9.
  function automatic string judge(input int a, input int n, input bit tr, input bit en,
                                  input int base, input int size, input int g);
    int last, csz;
    last = a + n - 1;
    csz  = 1 << g;
    if (!en) return "R3";
    if (!tr) return "R4";
    if (n == 0) return "R5";
    if (last > (1 << AW) - 1) return "R8";
    if (a < base || last >= base + size) return "R6";
    if ((a / csz) != (last / csz)) return "R7";
    return "R9";
  endfunction

  task automatic sweep(input bit en, input bit tr, input int base, input int size, input int g);
    string tag;
    @(negedge clk);
    req_valid      = 1'b0;
    dec_p2p_en     = en;
    req_translated = tr;
    dec_base       = AW'(base);
    dec_size       = (AW+1)'(size);
    dec_gran_log   = GW'(g);
    @(negedge clk);
    check3("R2 idle", rsp_valid, rsp_accept, rsp_abort, 1'b0, 1'b0, 1'b0);
    for (int a = 0; a < (1 << AW); a++) begin
      for (int n = 0; n < (1 << LW); n++) begin
        req_valid = 1'b1;
        req_addr  = AW'(a);
        req_len   = LW'(n);
        tag = judge(a, n, tr, en, base, size, g);
        @(negedge clk);
        if (tag == "R9")
          check3("R9 accept", rsp_valid, rsp_accept, rsp_abort, 1'b1, 1'b1, 1'b0);
        else
          check3({tag, " abort (R2)"}, rsp_valid, rsp_accept, rsp_abort, 1'b1, 1'b0, 1'b1);
      end
    end
    req_valid = 1'b0;
    @(negedge clk);
    check3("R2 after last", rsp_valid, rsp_accept, rsp_abort, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    // R1: outputs low during reset, with a request held at the inputs.
    req_valid = 1'b1;
    repeat (3) @(negedge clk);
    check3("R1 in reset", rsp_valid, rsp_accept, rsp_abort, 1'b0, 1'b0, 1'b0);
    req_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check3("R1 after reset", rsp_valid, rsp_accept, rsp_abort, 1'b0, 1'b0, 1'b0);

    sweep(1'b1, 1'b1, 8'h23, 9'h85, 3);   // R6/R7 overlap on unaligned edges
    sweep(1'b1, 1'b1, 0,     256,   7);   // full space, R8 at the top
    sweep(1'b1, 1'b1, 8'h40, 9'h40, 0);   // 1-byte chunks: R7 for every len > 1
    sweep(1'b1, 1'b1, 8'hF0, 9'h20, 4);   // window past the top: R8 with R6
    sweep(1'b0, 1'b1, 8'h10, 9'h80, 5);   // R3
    sweep(1'b1, 1'b0, 8'h10, 9'h80, 5);   // R4
    sweep(1'b1, 1'b1, 8'h10, 9'h00, 6);   // empty window: R6 everywhere

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule